// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Pin Interrupt Sensing

This block is a memory-mapped GPIO controller holding three banks of 32 pins. It is reached over a plain 32-bit register bus: an address, a write strobe, write data, and read data that follows the address combinationally. For each pin the block holds a direction bit, an input-inversion bit and an output value. Output values can be written directly, or changed atomically through set and clear registers, so that individual pins can be flipped without a read-modify-write.

Every pin can raise an interrupt on a rising edge, a falling edge, a high level or a low level. Each of these four conditions has its own enable register. A detected condition latches a pending bit. Software clears a pending bit by writing a one to it. A single combined interrupt output stays high while any pending bit in any bank is set. A separate read-only register shows which pending bits were caused by edges rather than levels. Pin inputs pass through a two-flop synchronizer before they are sensed.

Top module: `gpio_ctrl`

## Requirements
- R1: Register address = group offset + 4*bank, where address bits [7:4] select the group (0x0 direction, 0x1 polarity, 0x2 data, 0x3 set, 0x4 clear, 0x5 rising enable, 0x6 falling enable, 0x7 high-level enable, 0x8 low-level enable, 0x9 status, 0xA edge-source) and bits [3:2] select the bank (0..2). Bank 3 and groups above 0xA read as zero.
- R2: For each pin, a direction bit of 1 makes it an output, and `gpio_oe_o` mirrors the direction register. Outputs change only on a bus write.
- R3: A write to the set group drives to 1 every output bit written as one. A write to the clear group drives those bits to 0. Bits written as zero keep their value.
- R4: A read of the data group returns the output register for output pins and the synchronized, polarity-adjusted input for input pins.
- R5: A polarity bit of 1 inverts that pin's input sense, both for data reads and for interrupt detection. Polarity 0 leaves the input uninverted.
- R6: With its rising enable set, a 0-to-1 change of the pin sense sets the pin's status bit. Without the falling enable, a 1-to-0 change sets nothing.
- R7: With both edge enables set, a change in either direction sets the status bit.
- R8: With a high-level (low-level) enable set, the status bit is set on every cycle in which the sense is 1 (0). It therefore re-sets after a clear while the level persists.
- R9: Writing ones to the status group clears those bits, and zero bits have no effect. If a clear and an event hit the same bit in one cycle, the bit stays set.
- R10: `irq_o` is high exactly while any status bit of any bank is set.
- R11: The edge-source group reads 1 for pending bits set by an edge event and 0 for bits set by a level event.
- R12: Reset clears direction, polarity, output, enable, status and edge-source registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 8 | Register byte address |
| we_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 96 | Pin input levels, bank b at [32b+31:32b] |
| gpio_o | output | 96 | Output values |
| gpio_oe_o | output | 96 | Output enables |
| irq_o | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle: outputs and enables hold still without a write, a set or clear write affects exactly the written bits of bank 0, a pending interrupt cannot drop without a bus write, and unmapped groups read zero. Other behaviour depends on stimulus sequences and only the bench scenarios can show it. These are the synchronizer latency before an edge latches, the choice between edge and level sources, level re-assertion after a clear, a clear losing to a simultaneous event, polarity-driven detection, and the cross-bank OR of the interrupt line.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h1,
    GRP_DATA = 4'h2,
    GRP_SET  = 4'h3,
    GRP_CLR  = 4'h4,
    GRP_RISE = 4'h5,
    GRP_FALL = 4'h6,
    GRP_HIGH = 4'h7,
    GRP_LOW  = 4'h8,
    GRP_STAT = 4'h9,
    GRP_EDGE = 4'hA
  } grp_e;

  localparam int unsigned GRP_LSB  = 4;
  localparam int unsigned BANK_LSB = 2;
  localparam int unsigned BSEL_W   = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/gpio_detect.sv
module gpio_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  input  logic [W-1:0] high_en_i,
  input  logic [W-1:0] low_en_i,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] edge_evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sense_i;
  end

  logic [W-1:0] rise, fall, lvl;
  assign rise       = sense_i & ~prev_q & rise_en_i;
  assign fall       = ~sense_i & prev_q & fall_en_i;
  assign lvl        = (sense_i & high_en_i) | (~sense_i & low_en_i);
  assign edge_evt_o = rise | fall;
  assign evt_o      = rise | fall | lvl;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  input  logic         wr_i,
  input  grp_e         wr_grp_i,
  input  logic [W-1:0] wdata_i,
  input  grp_e         rd_grp_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] gpio_o,
  output logic [W-1:0] gpio_oe_o,
  output logic         pend_o
);
  logic [W-1:0] dir_q, pol_q, out_q;
  logic [W-1:0] rise_q, fall_q, high_q, low_q;
  logic [W-1:0] stat_q, edge_q;
  logic [W-1:0] sync, sense, evt, edge_evt, clr;

  gpio_sync #(.W(W)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  assign sense = sync ^ pol_q;

  gpio_detect #(.W(W)) u_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sense_i   (sense),
    .rise_en_i (rise_q),
    .fall_en_i (fall_q),
    .high_en_i (high_q),
    .low_en_i  (low_q),
    .evt_o     (evt),
    .edge_evt_o(edge_evt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      pol_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      high_q <= '0;
      low_q  <= '0;
    end else if (wr_i) begin
      unique case (wr_grp_i)
        GRP_DIR:  dir_q  <= wdata_i;
        GRP_POL:  pol_q  <= wdata_i;
        GRP_DATA: out_q  <= wdata_i;
        GRP_SET:  out_q  <= out_q | wdata_i;
        GRP_CLR:  out_q  <= out_q & ~wdata_i;
        GRP_RISE: rise_q <= wdata_i;
        GRP_FALL: fall_q <= wdata_i;
        GRP_HIGH: high_q <= wdata_i;
        GRP_LOW:  low_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  // write-one-to-clear; a same-cycle event keeps the bit
  assign clr = (wr_i && wr_grp_i == GRP_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      edge_q <= '0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      edge_q <= (edge_q & ~(clr | (evt & ~edge_evt))) | edge_evt;
    end
  end

  always_comb begin
    unique case (rd_grp_i)
      GRP_DIR:  rdata_o = dir_q;
      GRP_POL:  rdata_o = pol_q;
      GRP_DATA: rdata_o = (dir_q & out_q) | (~dir_q & sense);
      GRP_RISE: rdata_o = rise_q;
      GRP_FALL: rdata_o = fall_q;
      GRP_HIGH: rdata_o = high_q;
      GRP_LOW:  rdata_o = low_q;
      GRP_STAT: rdata_o = stat_q;
      GRP_EDGE: rdata_o = edge_q;
      default:  rdata_o = '0;
    endcase
  end

  assign gpio_o    = out_q;
  assign gpio_oe_o = dir_q;
  assign pend_o    = |stat_q;
endmodule

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NBANK  = 3,
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    we_i,
  input  logic [BANK_W-1:0]       wdata_i,
  output logic [BANK_W-1:0]       rdata_o,
  input  logic [NBANK*BANK_W-1:0] pin_i,
  output logic [NBANK*BANK_W-1:0] gpio_o,
  output logic [NBANK*BANK_W-1:0] gpio_oe_o,
  output logic                    irq_o
);
  localparam int unsigned NPIN = NBANK * BANK_W;

  grp_e              grp;
  logic [BSEL_W-1:0] bsel;
  logic              hi_zero;
  logic [BANK_W-1:0] bank_rd [NBANK];
  logic [NBANK-1:0]  pend;

  assign grp  = grp_e'(addr_i[GRP_LSB +: 4]);
  assign bsel = addr_i[BANK_LSB +: BSEL_W];

  generate
    if (ADDR_W > 8) begin : g_hi
      assign hi_zero = (addr_i[ADDR_W-1:8] == '0);
    end else begin : g_nohi
      assign hi_zero = 1'b1;
    end
  endgenerate

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = hi_zero && (bsel == BSEL_W'(b));

    gpio_bank #(.W(BANK_W)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .pin_i    (pin_i[b*BANK_W +: BANK_W]),
      .wr_i     (we_i && sel),
      .wr_grp_i (grp),
      .wdata_i  (wdata_i),
      .rd_grp_i (grp),
      .rdata_o  (bank_rd[b]),
      .gpio_o   (gpio_o[b*BANK_W +: BANK_W]),
      .gpio_oe_o(gpio_oe_o[b*BANK_W +: BANK_W]),
      .pend_o   (pend[b])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (hi_zero && bsel == BSEL_W'(b)) rdata_o = bank_rd[b];
    end
  end

  assign irq_o = |pend;

  logic unused_npin;
  assign unused_npin = (NPIN == 0);
endmodule

// File: rtl/gpio_ctrl_chk.sv
module gpio_ctrl_chk #(
  parameter int unsigned NBANK  = 3,
  parameter int unsigned BANK_W = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    we_i,
  input logic [BANK_W-1:0]       wdata_i,
  input logic [BANK_W-1:0]       rdata_o,
  input logic [NBANK*BANK_W-1:0] gpio_o,
  input logic [NBANK*BANK_W-1:0] gpio_oe_o,
  input logic                    irq_o
);
  // R2: outputs and enables move only on a bus write
  a_r2_hold_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(gpio_o) && $stable(gpio_oe_o)));

  // R3: set write forces written ones high in bank 0
  a_r3_set_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h30)) |=>
      ((gpio_o[BANK_W-1:0] & $past(wdata_i)) == $past(wdata_i)));

  // R3: clear write forces written ones low in bank 0
  a_r3_clr_bank0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h40)) |=>
      ((gpio_o[BANK_W-1:0] & $past(wdata_i)) == '0));

  // R3: zero bits of a set write keep their value
  a_r3_set_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_W'('h30)) |=>
      ((gpio_o[BANK_W-1:0] & ~$past(wdata_i)) == ($past(gpio_o[BANK_W-1:0]) & ~$past(wdata_i))));

  // R10: a pending interrupt only drops after a bus write
  a_r10_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !we_i) |=> irq_o);

  // R1: groups above the edge-source group read zero
  a_r1_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[7:4] > 4'hA) |-> (rdata_o == '0));
endmodule

bind gpio_ctrl gpio_ctrl_chk #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .addr_i   (addr_i),
  .we_i     (we_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .gpio_o   (gpio_o),
  .gpio_oe_o(gpio_oe_o),
  .irq_o    (irq_o)
);

// File: tb/gpio_ctrl_tb_top.sv
module gpio_ctrl_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [95:0] pin_i = '0;
  logic [95:0] gpio_o, gpio_oe_o;
  logic        irq_o;

  always #4 clk_i = ~clk_i;

  gpio_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i),
    .gpio_o(gpio_o), .gpio_oe_o(gpio_oe_o), .irq_o(irq_o)
  );

  typedef struct {
    int          kind;   // 0 rdata, 1 gpio_o, 2 gpio_oe_o, 3 irq_o
    int          lo;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: samples mid low phase
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        case (it.kind)
          0: act = rdata_o;
          1: act = gpio_o[it.lo +: 32];
          2: act = gpio_oe_o[it.lo +: 32];
          default: act = {31'd0, irq_o};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(int kind, int lo, logic [31:0] exp, string tag);
    item_t it;
    it.kind = kind; it.lo = lo; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic chk_now(logic [7:0] a, logic [31:0] exp, string tag);
    addr_i = a;
    push(0, 0, exp, tag);
  endtask

  task automatic chk(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk_i);
    we_i = 1'b0;
    chk_now(a, exp, tag);
  endtask

  task automatic chk_port(int kind, int lo, logic [31:0] exp, string tag);
    @(negedge clk_i);
    push(kind, lo, exp, tag);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (50000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R12 reset state
    chk(8'h00, 32'h0, "R12 dir reset");
    chk(8'h94, 32'h0, "R12 status reset");
    chk(8'h54, 32'h0, "R12 rise enable reset");
    chk_port(1, 0, 32'h0, "R12 gpio_o reset");
    chk_port(3, 0, 32'h0, "R12 irq reset");

    // R1 R2 address map and direction
    wr(8'h04, 32'hA5A5_0F0F);
    chk(8'h04, 32'hA5A5_0F0F, "R1 dir bank1 readback");
    chk(8'h00, 32'h0, "R1 dir bank0 untouched");
    chk(8'h08, 32'h0, "R1 dir bank2 untouched");
    chk(8'h0C, 32'h0, "R1 bank3 unmapped");
    chk(8'hB0, 32'h0, "R1 group B unmapped");
    chk_port(2, 32, 32'hA5A5_0F0F, "R2 oe bank1");

    // R3 set/clear
    wr(8'h30, 32'h0000_00FF);
    chk_port(1, 0, 32'h0000_00FF, "R3 set");
    wr(8'h40, 32'h0000_000F);
    chk_port(1, 0, 32'h0000_00F0, "R3 clear");
    wr(8'h30, 32'h0000_0100);
    chk_port(1, 0, 32'h0000_01F0, "R3 set keeps zeros");
    wr(8'h38, 32'h8000_0000);
    chk_port(1, 64, 32'h8000_0000, "R3 set bank2");
    chk_port(1, 0, 32'h0000_01F0, "R3 bank0 unchanged by bank2 set");

    // R4 R5 data read
    wr(8'h00, 32'h0000_FFFF);
    pin_i[31:0] = 32'h1234_5678;
    settle();
    chk(8'h20, 32'h1234_01F0, "R4 data mix");
    wr(8'h10, 32'h0001_0000);
    chk(8'h20, 32'h1235_01F0, "R5 polarity read");
    wr(8'h10, 32'h0);
    chk(8'h20, 32'h1234_01F0, "R5 polarity zero");
    pin_i = '0;
    settle();

    // R6 R11 rising edge
    wr(8'h54, 32'h1);
    pin_i[32] = 1'b1;
    settle();
    chk(8'h94, 32'h1, "R6 rising sets status");
    chk(8'hA4, 32'h1, "R11 edge source");
    chk_port(3, 0, 32'h1, "R10 irq on");

    // R9 zero bits ignored
    wr(8'h94, 32'h2);
    chk(8'h94, 32'h1, "R9 zero write no effect");

    // R8 low level, R11 level source
    wr(8'h80, 32'h0010_0000);
    settle();
    chk(8'h90, 32'h0010_0000, "R8 low level");
    chk(8'hA0, 32'h0, "R11 level source");

    // R10 OR across banks
    wr(8'h80, 32'h0);
    wr(8'h90, 32'h0010_0000);
    chk(8'h90, 32'h0, "R9 clear bank0");
    chk_port(3, 0, 32'h1, "R10 irq held by bank1");
    wr(8'h94, 32'h1);
    chk(8'h94, 32'h0, "R9 clear bank1");
    chk(8'hA4, 32'h0, "R11 edge cleared");
    chk_port(3, 0, 32'h0, "R10 irq off");

    // R6 falling ignored without enable
    pin_i[32] = 1'b0;
    settle();
    chk(8'h94, 32'h0, "R6 falling ignored");

    // R7 both edges
    wr(8'h58, 32'h8);
    wr(8'h68, 32'h8);
    pin_i[67] = 1'b1;
    settle();
    chk(8'h98, 32'h8, "R7 rise with both");
    wr(8'h98, 32'h8);
    chk(8'h98, 32'h0, "R7 clear");
    pin_i[67] = 1'b0;
    settle();
    chk(8'h98, 32'h8, "R7 fall with both");
    wr(8'h98, 32'h8);
    chk(8'h98, 32'h0, "R7 clear after fall");

    // R8 high level, R9 event wins
    wr(8'h74, 32'h10);
    pin_i[36] = 1'b1;
    settle();
    chk(8'h94, 32'h10, "R8 high level");
    chk(8'hA4, 32'h0, "R11 high level not edge");
    wr(8'h94, 32'h10);
    chk_now(8'h94, 32'h10, "R9 event wins over clear");
    pin_i[36] = 1'b0;
    settle();
    wr(8'h94, 32'h10);
    chk(8'h94, 32'h0, "R8 cleared after level gone");
    chk_port(3, 0, 32'h0, "R10 irq off after level");

    // R5 polarity in detection
    wr(8'h18, 32'h400);
    wr(8'h78, 32'h400);
    settle();
    chk(8'h98, 32'h400, "R5 inverted sense high level");
    wr(8'h18, 32'h0);
    wr(8'h98, 32'h400);
    chk(8'h98, 32'h0, "R5 normal sense no level");
    chk_port(3, 0, 32'h0, "R10 irq final");

    repeat (2) @(negedge clk_i);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule